// File: doc/BRIEF.md
# Acceptance-Rate Balancing Arbiter

This block shares one resource among three requesters. It does not use a fixed or rotating priority. It gives the resource to the requester that has been served least often relative to how often it asked. For each requester it keeps a count of cycles in which it asked and a count of cycles in which it was served. A shared serial divider turns the two counts into an integer percentage, 0 to 100. Each percentage is graded into one of three fuzzy bands (low, medium, high) using overlapping piecewise-linear membership curves. The band with the strongest membership becomes that requester's crisp class.

In every cycle, the requesting master in the lowest class is served. When two or more requesters share that class, the one with the lowest index is served. The request and grant lines are plain per-cycle levels with no data payload, so there is no valid/ready stream and no back-pressure. A requester that is not served simply keeps its request line high. Grants are registered: the request sampled at one rising edge is answered by the grant visible after that edge.

Top module: `fuzzy_acc_arbiter`

## Requirements
- R1: `gnt_o` carries at most one set bit. It is the registered answer to `req_i` sampled at the same rising edge, and it never has a bit set for a master whose request was low at that edge.
- R2: When exactly one request bit is high, that master is granted in the following cycle, whatever its class.
- R3: When no request bit is high, `gnt_o` is all zeros in the following cycle.
- R4: Each master's rate is floor(100 × served ÷ asked), and it is 0 while the master has never asked. A master's counts move only in cycles where it asks: asked +1, and served +1 if it is picked in that cycle.
- R5: The class of a rate is the band with the largest membership, with ties going to the lower band. Low has full membership up to 18 and falls to zero at 36. Medium rises from 18 to a peak at 36 and falls to zero at 72. High rises from 36 and is full from 72. With the fixed-point slopes this gives: rate 0 to 27 is low, 28 to 54 is medium, and 55 and above is high. The encoding is low = 0, medium = 1, high = 2.
- R6: With several requesters, the master granted is one whose class is the lowest among the requesting masters. Non-requesting masters take no part.
- R7: Among requesting masters that share the lowest class, the lowest bit index of `req_i` wins: bit 0 before bit 1, and bit 1 before bit 2.
- R8: When a master's asked count would reach 255, both of its counts are halved together, rounding down, so the asked count becomes 127. The served count never exceeds the asked count.
- R9: During and right after reset, `gnt_o` is zero and all counts and rates are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 3 | Per-master request level, sampled each rising edge |
| gnt_o | output | 3 | Registered one-hot-or-zero grant |

## Verification
The assertions assume that `req_i` is a clean level that is stable around each rising edge. They also assume that counts only change through sampled requests. The rule and band checks compare the grant against the classes held at the sampling edge, not against the exact counts.

The class seen by the arbiter lags the counts by up to two divider rounds. The stimulus therefore drives requests on the falling edge. After every contended cycle and every single-requester burst, it inserts an idle stretch longer than two full refresh rounds. This keeps the expected winner, computed from the bench's own counts, identical to what the hardware holds when it decides.

// File: rtl/fz_arb_pkg.sv
package fz_arb_pkg;
  typedef enum logic [1:0] {
    CAT_LOW  = 2'd0,
    CAT_MED  = 2'd1,
    CAT_HIGH = 2'd2
  } cat_e;

  typedef enum logic [1:0] {
    DV_LOAD  = 2'd0,
    DV_RUN   = 2'd1,
    DV_STORE = 2'd2
  } div_state_e;
endpackage

// File: rtl/acc_counter.sv
module acc_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          pick_i,
  output logic [CW-1:0] asked_o,
  output logic [CW-1:0] served_o
);
  localparam logic [CW:0] LIMIT = (CW+1)'((2**CW) - 1);

  logic [CW-1:0] asked_q, served_q;
  logic [CW:0]   asked_nx, served_nx;

  always_comb begin
    asked_nx  = {1'b0, asked_q} + (CW+1)'(1);
    served_nx = {1'b0, served_q} + (CW+1)'(pick_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asked_q  <= '0;
      served_q <= '0;
    end else if (req_i) begin
      if (asked_nx == LIMIT) begin
        asked_q  <= asked_nx[CW:1];
        served_q <= served_nx[CW:1];
      end else begin
        asked_q  <= asked_nx[CW-1:0];
        served_q <= served_nx[CW-1:0];
      end
    end
  end

  assign asked_o  = asked_q;
  assign served_o = served_q;

  a_r8_served_le_asked: assert property (@(posedge clk) disable iff (!rst_n)
    served_q <= asked_q);
  a_r8_asked_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, asked_q} < LIMIT);
  a_r8_halve_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && ({1'b0, asked_q} == LIMIT - 1)) |=> (asked_q == LIMIT[CW:1]));
  a_r4_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> ($stable(asked_q) && $stable(served_q)));
  a_r1_pick_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    pick_i |-> req_i);
endmodule

// File: rtl/rate_divider.sv
module rate_divider
  import fz_arb_pkg::*;
#(
  parameter int NM  = 3,
  parameter int CW  = 8,
  parameter int PCT = 100
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NM-1:0][CW-1:0]  asked_i,
  input  logic [NM-1:0][CW-1:0]  served_i,
  output logic [NM-1:0][CW-1:0]  rate_o
);
  localparam int NW = CW + $clog2(PCT + 1);
  localparam int IW = (NM > 1) ? $clog2(NM) : 1;
  localparam int SW = $clog2(NW + 1);
  localparam logic [NW-1:0] RMAX = NW'((2**CW) - 1);

  div_state_e              st;
  logic [IW-1:0]           idx;
  logic [SW-1:0]           step;
  logic [NW-1:0]           num, quo;
  logic [CW-1:0]           den, rem;
  logic [NM-1:0][CW-1:0]   rate_q;
  logic [CW:0]             shifted, diff;
  logic                    fits;

  always_comb begin
    shifted = {rem, num[NW-1]};
    fits    = shifted >= {1'b0, den};
    diff    = shifted - {1'b0, den};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= DV_LOAD;
      idx    <= '0;
      step   <= '0;
      num    <= '0;
      quo    <= '0;
      den    <= '0;
      rem    <= '0;
      rate_q <= '0;
    end else begin
      unique case (st)
        DV_LOAD: begin
          num  <= NW'(served_i[idx]) * NW'(PCT);
          den  <= asked_i[idx];
          rem  <= '0;
          quo  <= '0;
          step <= SW'(NW);
          st   <= (asked_i[idx] == '0) ? DV_STORE : DV_RUN;
        end
        DV_RUN: begin
          rem  <= fits ? diff[CW-1:0] : shifted[CW-1:0];
          quo  <= {quo[NW-2:0], fits};
          num  <= num << 1;
          step <= step - SW'(1);
          if (step == SW'(1)) st <= DV_STORE;
        end
        DV_STORE: begin
          rate_q[idx] <= (quo > RMAX) ? '1 : quo[CW-1:0];
          idx         <= (idx == IW'(NM - 1)) ? '0 : idx + IW'(1);
          st          <= DV_LOAD;
        end
        default: st <= DV_LOAD;
      endcase
    end
  end

  assign rate_o = rate_q;

  for (genvar g = 0; g < NM; g++) begin : g_chk
    a_r4_rate_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      rate_q[g] <= CW'(PCT));
    a_r4_zero_until_asked: assert property (@(posedge clk) disable iff (!rst_n)
      (asked_i[g] == '0) |-> (rate_q[g] == '0));
  end
endmodule

// File: rtl/fuzz_class.sv
module fuzz_class
  import fz_arb_pkg::*;
#(
  parameter int CW     = 8,
  parameter int BP_A   = 18,
  parameter int BP_B   = 36,
  parameter int BP_C   = 72,
  parameter int MU_MAX = 255
) (
  input  logic [CW-1:0] rate_i,
  output cat_e          cat_o
);
  localparam int SLOPE_LO = MU_MAX / (BP_B - BP_A);
  localparam int SLOPE_HI = MU_MAX / (BP_C - BP_B);

  int x, mu_lo, mu_md, mu_hi, best;

  always_comb begin
    x = int'(rate_i);
    if (x <= BP_A)      mu_lo = MU_MAX;
    else if (x < BP_B)  mu_lo = MU_MAX - (x - BP_A) * SLOPE_LO;
    else                mu_lo = 0;

    if (x <= BP_A)      mu_md = 0;
    else if (x <= BP_B) mu_md = (x - BP_A) * SLOPE_LO;
    else if (x < BP_C)  mu_md = MU_MAX - (x - BP_B) * SLOPE_HI;
    else                mu_md = 0;
    if (mu_md > MU_MAX) mu_md = MU_MAX;
    if (mu_md < 0)      mu_md = 0;

    if (x <= BP_B)      mu_hi = 0;
    else if (x < BP_C)  mu_hi = (x - BP_B) * SLOPE_HI;
    else                mu_hi = MU_MAX;

    cat_o = CAT_LOW;
    best  = mu_lo;
    if (mu_md > best) begin
      cat_o = CAT_MED;
      best  = mu_md;
    end
    if (mu_hi > best) begin
      cat_o = CAT_HIGH;
      best  = mu_hi;
    end
  end
endmodule

// File: rtl/rule_select.sv
module rule_select
  import fz_arb_pkg::*;
#(
  parameter int NM = 3
) (
  input  logic [NM-1:0] req_i,
  input  cat_e          cat_i [NM],
  output logic [NM-1:0] pick_o
);
  cat_e best;
  logic found;

  always_comb begin
    pick_o = '0;
    best   = CAT_HIGH;
    found  = 1'b0;
    for (int i = 0; i < NM; i++) begin
      if (req_i[i] && (!found || (cat_i[i] < best))) begin
        found     = 1'b1;
        best      = cat_i[i];
        pick_o    = '0;
        pick_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fuzzy_acc_arbiter.sv
module fuzzy_acc_arbiter
  import fz_arb_pkg::*;
#(
  parameter int NM   = 3,
  parameter int CW   = 8,
  parameter int PCT  = 100,
  parameter int BP_A = 18,
  parameter int BP_B = 36,
  parameter int BP_C = 72
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] req_i,
  output logic [NM-1:0] gnt_o
);
  localparam int LOW_TOP = (BP_A + BP_B) / 2;
  localparam int MED_TOP = (BP_B + BP_C) / 2;

  logic [NM-1:0][CW-1:0] asked, served, rates;
  cat_e                  cats [NM];
  logic [NM-1:0]         pick, gnt_q;

  for (genvar i = 0; i < NM; i++) begin : g_master
    acc_counter #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (req_i[i]),
      .pick_i   (pick[i]),
      .asked_o  (asked[i]),
      .served_o (served[i])
    );
    fuzz_class #(.CW(CW), .BP_A(BP_A), .BP_B(BP_B), .BP_C(BP_C)) u_fz (
      .rate_i (rates[i]),
      .cat_o  (cats[i])
    );
  end

  rate_divider #(.NM(NM), .CW(CW), .PCT(PCT)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .asked_i  (asked),
    .served_i (served),
    .rate_o   (rates)
  );

  rule_select #(.NM(NM)) u_rule (
    .req_i  (req_i),
    .cat_i  (cats),
    .pick_o (pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt_q <= '0;
    else        gnt_q <= pick;
  end

  assign gnt_o = gnt_q;

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));
  a_r1_granted_requested: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_o & ~$past(req_i)) == '0));
  a_r2_lone_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(req_i) |=> (gnt_o == $past(req_i)));
  a_r3_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |=> (gnt_o == '0));

  for (genvar i = 0; i < NM; i++) begin : g_band
    a_r5_low_band: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rates[i]) <= LOW_TOP) |-> (cats[i] == CAT_LOW));
    a_r5_mid_band: assert property (@(posedge clk) disable iff (!rst_n)
      ((int'(rates[i]) > LOW_TOP) && (int'(rates[i]) <= MED_TOP)) |-> (cats[i] == CAT_MED));
    a_r5_high_band: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rates[i]) > MED_TOP) |-> (cats[i] == CAT_HIGH));
    for (genvar j = 0; j < NM; j++) begin : g_pair
      if (j != i) begin : g_ne
        a_r6_lowest_class: assert property (@(posedge clk) disable iff (!rst_n)
          (gnt_o[i] && $past(req_i[j])) |-> ($past(cats[j]) >= $past(cats[i])));
      end
      if (j < i) begin : g_lo
        a_r7_index_tiebreak: assert property (@(posedge clk) disable iff (!rst_n)
          (gnt_o[i] && $past(req_i[j])) |-> ($past(cats[j]) > $past(cats[i])));
      end
    end
  end
endmodule

// File: tb/fuzzy_acc_arbiter_tb_top.sv
module fuzzy_acc_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] req;
  logic [2:0] gnt;

  always #5 clk = ~clk;

  fuzzy_acc_arbiter dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (req),
    .gnt_o (gnt)
  );

  typedef struct {
    logic [2:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int n_run  = 0;
  int n_fail = 0;
  int m_ask[3];
  int m_srv[3];

  function automatic int m_rate(input int s, input int a);
    return (a == 0) ? 0 : (100 * s) / a;
  endfunction

  function automatic int m_cat(input int r);
    if (r <= 27) return 0;
    if (r <= 54) return 1;
    return 2;
  endfunction

  task automatic drive(input logic [2:0] rv, input string force_tag);
    item_t it;
    int    best, win, nreq, ties;
    @(negedge clk);
    req  = rv;
    best = 3;
    win  = -1;
    nreq = 0;
    for (int i = 0; i < 3; i++) begin
      if (rv[i]) begin
        nreq++;
        if (m_cat(m_rate(m_srv[i], m_ask[i])) < best) begin
          best = m_cat(m_rate(m_srv[i], m_ask[i]));
          win  = i;
        end
      end
    end
    ties = 0;
    for (int i = 0; i < 3; i++)
      if (rv[i] && m_cat(m_rate(m_srv[i], m_ask[i])) == best) ties++;
    it.exp = '0;
    if (win >= 0) it.exp[win] = 1'b1;
    if (force_tag != "")  it.tag = force_tag;
    else if (nreq == 0)   it.tag = "R3";
    else if (nreq == 1)   it.tag = "R1,R2";
    else if (ties > 1)    it.tag = "R5,R7";
    else                  it.tag = "R5,R6";
    q.push_back(it);
    for (int i = 0; i < 3; i++) begin
      if (rv[i]) begin
        m_ask[i]++;
        if (i == win) m_srv[i]++;
        if (m_ask[i] == 255) begin
          m_ask[i] = m_ask[i] / 2;
          m_srv[i] = m_srv[i] / 2;
        end
      end
    end
  endtask

  task automatic settle();
    repeat (120) drive(3'b000, "");
  endtask

  task automatic contend(input logic [2:0] rv, input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      drive(rv, tag);
      settle();
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        n_run++;
        if (gnt !== it.exp) begin
          n_fail++;
          $display("FAIL %s: gnt=%b expected %b", it.tag, gnt, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run incomplete, expected finish before limit");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : stim
    int need;
    for (int i = 0; i < 3; i++) begin
      m_ask[i] = 0;
      m_srv[i] = 0;
    end
    rst_n = 1'b0;
    req   = 3'b000;
    repeat (3) @(negedge clk);
    n_run++;
    if (gnt !== 3'b000) begin
      n_fail++;
      $display("FAIL R9: gnt=%b expected 000 in reset", gnt);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_run++;
    if (gnt !== 3'b000) begin
      n_fail++;
      $display("FAIL R9: gnt=%b expected 000 after reset", gnt);
    end
    drive(3'b000, "R3,R9");
    // R4: all rates start at 0, so all low and master 0 wins
    drive(3'b111, "R4,R7");
    settle();
    contend(3'b111, 12, "");
    contend(3'b011, 6, "");
    contend(3'b110, 6, "");
    contend(3'b101, 6, "");
    for (int k = 0; k < 20; k++) drive(3'b100, "R2");
    settle();
    contend(3'b111, 6, "");
    // R8: drive master 1 alone until its asked count wraps to the halved value
    need = 255 - m_ask[1];
    for (int k = 0; k < need; k++) drive(3'b010, "R2,R8");
    settle();
    contend(3'b110, 30, "R8");
    contend(3'b111, 10, "R8");
    contend(3'b011, 4, "");
    wait (q.size() == 0);
    @(posedge clk);
    #2;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule